// File: doc/BRIEF.md
# Programmable Output Macrocell

This block is one output cell of a small programmable logic device. A handful of native product terms, plus any product terms lent by neighbouring cells, are summed by an OR. A polarity bit can then invert the sum. The result either feeds a storage element or passes straight through. The storage element is set by a two-bit mode field to act as a D, T, JK or SR flip-flop. It is clocked on the rising edge of either the global clock or a dedicated product term. Product terms also drive its asynchronous active-high preset and clear.

A static configuration word chooses four things: the clock source, the flip-flop type, whether the pin shows the registered or the combinational value, and which borrowed terms take part. The selected value drives the pin and the feedback line into the array. A host processor can also load the flip-flop, or read it back, through one bit of an eight-bit data bus. The cell's index selects that bit.

Top module: `pld_out_cell`

## Requirements
- R1: The cell's sum is the OR of all native terms and of every borrowed term whose enable bit is 1. When `cfg_inv` is 1 that sum is inverted.
- R2: A borrowed term whose bit in `cfg_bor_en` is 0 has no effect on the sum, whatever its level.
- R3: With `cfg_reg_out`=0, `pin_out` and `fb_out` both equal the sum combinationally. With `cfg_reg_out`=1, both equal the flip-flop state.
- R4: With `cfg_mode`=2'b00 (D), the flip-flop takes the sum at each active clock edge.
- R5: With `cfg_mode`=2'b01 (T), the flip-flop inverts at an active edge when the sum is 1, and holds when the sum is 0.
- R6: With `cfg_mode`=2'b10 (JK), J is the sum and K is `pt_k`. The flip-flop holds on 00, clears on J=0/K=1, sets on J=1/K=0, and inverts on 11.
- R7: With `cfg_mode`=2'b11 (SR), S is the sum and R is `pt_k`. It sets on S only, clears on R only, and holds when neither or both are 1.
- R8: With `cfg_clk_pt`=0 the active edge is the rising edge of `clk_glb`, and `pt_clk` is ignored. With `cfg_clk_pt`=1 the active edge is the rising edge of `pt_clk`, and `clk_glb` edges are ignored.
- R9: While `pt_pre` is 1 and no clear term is 1, the flip-flop is 1, set asynchronously without waiting for a clock edge.
- R10: The clear is the OR of the two bits of `pt_clr`. It forces the flip-flop to 0 asynchronously and wins over the preset.
- R11: With `bus_ld`=1 at an active edge, the flip-flop takes `bus_wdata[CELL_IDX]` instead of its mode function. CELL_IDX defaults to 5.
- R12: With `bus_rd`=1, `bus_rdata` carries the flip-flop state at bit CELL_IDX and 0 on every other bit. With `bus_rd`=0, `bus_rdata` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_glb | input | 1 | Global clock |
| pt_nat | input | NAT_PT | Native product terms |
| pt_bor | input | BOR_PT | Product terms lent by neighbouring cells |
| pt_k | input | 1 | Second term: K in JK mode, R in SR mode |
| pt_clk | input | 1 | Product-term clock |
| pt_pre | input | 1 | Preset term, active high |
| pt_clr | input | CLR_PT | Clear terms, ORed, active high |
| cfg_bor_en | input | BOR_PT | Enable mask for borrowed terms |
| cfg_inv | input | 1 | Invert the summed terms |
| cfg_mode | input | 2 | Flip-flop type: 00 D, 01 T, 10 JK, 11 SR |
| cfg_clk_pt | input | 1 | 1 selects the product-term clock |
| cfg_reg_out | input | 1 | 1 selects the registered value for pin and feedback |
| bus_wdata | input | BUS_W | Host data bus, write side |
| bus_ld | input | 1 | Load strobe, sampled at the active edge |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | BUS_W | Host data bus, read side |
| pin_out | output | 1 | Port-pin value |
| fb_out | output | 1 | Feedback into the array |

## Verification
A vector table walks the D, T, JK and SR modes through every input combination that separates them. These include toggle against hold, JK 11 against SR 11, and polarity inversion turning an all-zero sum into a set. Borrowed terms are raised once with their enable set and once with it cleared, so that masking is shown to matter. Directed cases then show the following:
- the combinational pin path;
- the load taking priority over the mode function;
- readback landing only on the cell's bus bit;
- the global clock being ignored while the product-term clock is selected;
- clear winning over a preset that is held at the same time.

// File: rtl/pld_omc_pkg.sv
package pld_omc_pkg;

   typedef enum logic [1:0] {
      FF_D  = 2'b00,
      FF_T  = 2'b01,
      FF_JK = 2'b10,
      FF_SR = 2'b11
   } ff_mode_t;

endpackage

// File: rtl/omc_term_sum.sv
module omc_term_sum #(
   parameter int NAT_PT = 3,
   parameter int BOR_PT = 6
) (
   input  logic [NAT_PT-1:0] nat_i,
   input  logic [BOR_PT-1:0] bor_i,
   input  logic [BOR_PT-1:0] bor_en_i,
   input  logic              inv_i,
   output logic              sum_o
);
   logic [BOR_PT-1:0] bor_gated;

   // each borrowed term passes only when its mask bit is set
   for (genvar g = 0; g < BOR_PT; g++) begin : g_bor
      assign bor_gated[g] = bor_i[g] & bor_en_i[g];
   end

   assign sum_o = ((|nat_i) | (|bor_gated)) ^ inv_i;
endmodule

// File: rtl/omc_flop.sv
module omc_flop
   import pld_omc_pkg::*;
(
   input  logic       clk_i,
   input  logic       clr_i,
   input  logic       pre_i,
   input  logic       ld_i,
   input  logic       ld_bit_i,
   input  logic       s_i,
   input  logic       r_i,
   input  logic [1:0] mode_i,
   output logic       q_o
);
   ff_mode_t mode;
   logic     q_nxt;

   assign mode = ff_mode_t'(mode_i);

   always_comb begin
      unique case (mode)
         FF_D:  q_nxt = s_i;
         FF_T:  q_nxt = q_o ^ s_i;
         FF_JK: q_nxt = (s_i & ~q_o) | (~r_i & q_o);
         FF_SR: q_nxt = (s_i & ~r_i) | (q_o & ~(r_i & ~s_i));
         default: q_nxt = q_o;
      endcase
   end

   always_ff @(posedge clk_i or posedge clr_i or posedge pre_i) begin
      if (clr_i)      q_o <= 1'b0;
      else if (pre_i) q_o <= 1'b1;
      else if (ld_i)  q_o <= ld_bit_i;
      else            q_o <= q_nxt;
   end

   AST_D_CAPTURE: assert property (@(posedge clk_i) disable iff (clr_i || pre_i)
      (!ld_i && mode == FF_D) |=> (q_o == $past(s_i)));                   // R4
   AST_T_TOGGLE: assert property (@(posedge clk_i) disable iff (clr_i || pre_i)
      (!ld_i && mode == FF_T && s_i) |=> (q_o != $past(q_o)));            // R5
   AST_JK_FLIP: assert property (@(posedge clk_i) disable iff (clr_i || pre_i)
      (!ld_i && mode == FF_JK && s_i && r_i) |=> (q_o != $past(q_o)));    // R6
   AST_SR_HOLD: assert property (@(posedge clk_i) disable iff (clr_i || pre_i)
      (!ld_i && mode == FF_SR && s_i && r_i) |=> $stable(q_o));           // R7
   AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (clr_i || pre_i)
      ld_i |=> (q_o == $past(ld_bit_i)));                                 // R11
endmodule

// File: rtl/omc_bus_bit.sv
module omc_bus_bit #(
   parameter int BUS_W    = 8,
   parameter int CELL_IDX = 5
) (
   input  logic [BUS_W-1:0] wdata_i,
   input  logic             rd_i,
   input  logic             q_i,
   output logic             ld_bit_o,
   output logic [BUS_W-1:0] rdata_o
);
   assign ld_bit_o = wdata_i[CELL_IDX];

   for (genvar b = 0; b < BUS_W; b++) begin : g_rd
      if (b == CELL_IDX) begin : g_own
         assign rdata_o[b] = rd_i & q_i;
      end else begin : g_other
         assign rdata_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
   import pld_omc_pkg::*;
#(
   parameter int NAT_PT   = 3,
   parameter int BOR_PT   = 6,
   parameter int CLR_PT   = 2,
   parameter int BUS_W    = 8,
   parameter int CELL_IDX = 5
) (
   input  logic              clk_glb,
   input  logic [NAT_PT-1:0] pt_nat,
   input  logic [BOR_PT-1:0] pt_bor,
   input  logic              pt_k,
   input  logic              pt_clk,
   input  logic              pt_pre,
   input  logic [CLR_PT-1:0] pt_clr,
   input  logic [BOR_PT-1:0] cfg_bor_en,
   input  logic              cfg_inv,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_clk_pt,
   input  logic              cfg_reg_out,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic              bus_ld,
   input  logic              bus_rd,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              pin_out,
   output logic              fb_out
);
   localparam int TERM_TOTAL = NAT_PT + BOR_PT;

   if (NAT_PT < 3 || NAT_PT > 4) begin : g_bad_nat
      $error("pld_out_cell: NAT_PT must be 3 or 4");
   end
   if (BOR_PT < 1 || BOR_PT > 6) begin : g_bad_bor
      $error("pld_out_cell: BOR_PT must be 1 to 6");
   end
   if (CLR_PT < 1 || CLR_PT > 2) begin : g_bad_clr
      $error("pld_out_cell: CLR_PT must be 1 or 2");
   end
   if (CELL_IDX < 0 || CELL_IDX >= BUS_W) begin : g_bad_idx
      $error("pld_out_cell: CELL_IDX outside the bus");
   end
   if (TERM_TOTAL > 10) begin : g_bad_total
      $error("pld_out_cell: too many terms for one cell");
   end

   logic sum;
   logic ff_clk;
   logic clr_any;
   logic ld_bit;
   logic ff_q;
   logic sel_out;

   omc_term_sum #(.NAT_PT(NAT_PT), .BOR_PT(BOR_PT)) u_sum (
      .nat_i    (pt_nat),
      .bor_i    (pt_bor),
      .bor_en_i (cfg_bor_en),
      .inv_i    (cfg_inv),
      .sum_o    (sum)
   );

   assign ff_clk  = cfg_clk_pt ? pt_clk : clk_glb;
   assign clr_any = |pt_clr;

   omc_bus_bit #(.BUS_W(BUS_W), .CELL_IDX(CELL_IDX)) u_bus (
      .wdata_i  (bus_wdata),
      .rd_i     (bus_rd),
      .q_i      (ff_q),
      .ld_bit_o (ld_bit),
      .rdata_o  (bus_rdata)
   );

   omc_flop u_ff (
      .clk_i    (ff_clk),
      .clr_i    (clr_any),
      .pre_i    (pt_pre),
      .ld_i     (bus_ld),
      .ld_bit_i (ld_bit),
      .s_i      (sum),
      .r_i      (pt_k),
      .mode_i   (cfg_mode),
      .q_o      (ff_q)
   );

   assign sel_out = cfg_reg_out ? ff_q : sum;
   assign pin_out = sel_out;
   assign fb_out  = sel_out;

   AST_CLR_WINS: assert property (@(posedge clk_glb)
      clr_any |-> (ff_q == 1'b0));                                        // R10
   AST_PRE_SETS: assert property (@(posedge clk_glb)
      ($past(pt_pre && !clr_any) && pt_pre && !clr_any) |-> ff_q);        // R9
   AST_RD_MATCH: assert property (@(posedge clk_glb)
      (bus_rd && cfg_reg_out) |-> (bus_rdata[CELL_IDX] == pin_out));      // R12
   AST_RD_IDLE: assert property (@(posedge clk_glb)
      !bus_rd |-> (bus_rdata == '0));                                     // R12
endmodule

// File: tb/pld_out_cell_tb.sv
module pld_out_cell_tb_top;
   logic       clk_glb = 1'b0;
   logic [2:0] pt_nat = '0;
   logic [5:0] pt_bor = '0;
   logic       pt_k = 1'b0;
   logic       pt_clk = 1'b0;
   logic       pt_pre = 1'b0;
   logic [1:0] pt_clr = '0;
   logic [5:0] cfg_bor_en = '0;
   logic       cfg_inv = 1'b0;
   logic [1:0] cfg_mode = 2'b00;
   logic       cfg_clk_pt = 1'b0;
   logic       cfg_reg_out = 1'b1;
   logic [7:0] bus_wdata = '0;
   logic       bus_ld = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       pin_out;
   logic       fb_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   pld_out_cell dut_i (
      .clk_glb(clk_glb), .pt_nat(pt_nat), .pt_bor(pt_bor), .pt_k(pt_k),
      .pt_clk(pt_clk), .pt_pre(pt_pre), .pt_clr(pt_clr),
      .cfg_bor_en(cfg_bor_en), .cfg_inv(cfg_inv), .cfg_mode(cfg_mode),
      .cfg_clk_pt(cfg_clk_pt), .cfg_reg_out(cfg_reg_out),
      .bus_wdata(bus_wdata), .bus_ld(bus_ld), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .pin_out(pin_out), .fb_out(fb_out)
   );

   always #10 clk_glb = ~clk_glb;   // 50 MHz

   // {mode, inv, nat, bor, bor_en, k, expected q}
   localparam logic [19:0] VEC [18] = '{
      {2'd0, 1'b0, 3'b001, 6'b000000, 6'b000000, 1'b0, 1'b1},  // R4 R1
      {2'd0, 1'b1, 3'b001, 6'b000000, 6'b000000, 1'b0, 1'b0},  // R1 inv
      {2'd0, 1'b0, 3'b000, 6'b000100, 6'b000100, 1'b0, 1'b1},  // R1 borrowed
      {2'd0, 1'b0, 3'b000, 6'b000100, 6'b000000, 1'b0, 1'b0},  // R2 masked
      {2'd1, 1'b0, 3'b010, 6'b000000, 6'b000000, 1'b0, 1'b1},  // R5 toggle
      {2'd1, 1'b0, 3'b000, 6'b000000, 6'b000000, 1'b0, 1'b1},  // R5 hold
      {2'd1, 1'b0, 3'b000, 6'b100000, 6'b100000, 1'b0, 1'b0},  // R5 toggle
      {2'd2, 1'b0, 3'b100, 6'b000000, 6'b000000, 1'b0, 1'b1},  // R6 set
      {2'd2, 1'b0, 3'b000, 6'b000000, 6'b000000, 1'b0, 1'b1},  // R6 hold
      {2'd2, 1'b0, 3'b100, 6'b000000, 6'b000000, 1'b1, 1'b0},  // R6 flip
      {2'd2, 1'b0, 3'b100, 6'b000000, 6'b000000, 1'b1, 1'b1},  // R6 flip
      {2'd2, 1'b0, 3'b000, 6'b000000, 6'b000000, 1'b1, 1'b0},  // R6 clear
      {2'd3, 1'b0, 3'b001, 6'b000000, 6'b000000, 1'b0, 1'b1},  // R7 set
      {2'd3, 1'b0, 3'b001, 6'b000000, 6'b000000, 1'b1, 1'b1},  // R7 both hold
      {2'd3, 1'b0, 3'b000, 6'b000000, 6'b000000, 1'b1, 1'b0},  // R7 reset
      {2'd3, 1'b0, 3'b001, 6'b000000, 6'b000000, 1'b1, 1'b0},  // R7 both hold
      {2'd3, 1'b0, 3'b000, 6'b000000, 6'b000000, 1'b0, 1'b0},  // R7 none
      {2'd0, 1'b1, 3'b000, 6'b000000, 6'b000000, 1'b0, 1'b1}   // R1 R4 inv
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk_glb);
      #5;
   endtask

   initial begin
      #1 pt_clr = 2'b01;
      #4;
      check("R10 reset pin", {7'b0, pin_out}, 8'h00);
      check("R12 reset rdata", bus_rdata, 8'h00);
      pt_clr = 2'b00;

      for (int i = 0; i < 18; i++) begin
         cfg_mode   = VEC[i][19:18];
         cfg_inv    = VEC[i][17];
         pt_nat     = VEC[i][16:14];
         pt_bor     = VEC[i][13:8];
         cfg_bor_en = VEC[i][7:2];
         pt_k       = VEC[i][1];
         tick();
         check($sformatf("R4-7 vector %0d", i), {7'b0, pin_out}, {7'b0, VEC[i][0]});
      end

      // R3 combinational path
      cfg_reg_out = 1'b0; cfg_mode = 2'b00; cfg_inv = 1'b0;
      pt_nat = 3'b001; pt_bor = '0; cfg_bor_en = '0; pt_k = 1'b0;
      #1;
      check("R3 comb pin", {7'b0, pin_out}, 8'h01);
      check("R3 comb fb", {7'b0, fb_out}, 8'h01);
      cfg_inv = 1'b1;
      #1;
      check("R3 comb inverted", {6'b0, pin_out, fb_out}, 8'h00);
      cfg_inv = 1'b0; pt_nat = 3'b000; cfg_reg_out = 1'b1;

      // R11 load overrides D function (sum = 0)
      bus_wdata = 8'h20; bus_ld = 1'b1;
      tick();
      check("R11 load one", {7'b0, pin_out}, 8'h01);
      bus_wdata = 8'hDF;
      tick();
      check("R11 load zero", {7'b0, pin_out}, 8'h00);
      bus_wdata = 8'h20;
      tick();
      bus_ld = 1'b0; cfg_mode = 2'b01;   // T with sum 0 holds

      // R12 readback
      bus_rd = 1'b1;
      #1;
      check("R12 read bit", bus_rdata, 8'h20);
      bus_rd = 1'b0;
      #1;
      check("R12 read idle", bus_rdata, 8'h00);

      // R8 product-term clock (q is 1, D with sum 0 wants 0)
      @(negedge clk_glb);
      cfg_clk_pt = 1'b1; cfg_mode = 2'b00;
      tick();
      check("R8 global clock ignored", {7'b0, pin_out}, 8'h01);
      pt_clk = 1'b1; #2; pt_clk = 1'b0; #2;
      check("R8 pt clock edge", {7'b0, pin_out}, 8'h00);
      @(negedge clk_glb);
      cfg_clk_pt = 1'b0;
      #2;

      // R9 / R10 preset and clear
      pt_pre = 1'b1;
      #1;
      check("R9 async preset", {7'b0, pin_out}, 8'h01);
      pt_clr = 2'b10;
      #1;
      check("R10 clear over preset", {7'b0, pin_out}, 8'h00);
      tick();
      check("R10 clear held", {7'b0, pin_out}, 8'h00);
      pt_clr = 2'b00;
      tick();
      check("R9 preset after clear", {7'b0, pin_out}, 8'h01);
      pt_pre = 1'b0;
      tick();
      check("R4 after preset", {7'b0, pin_out}, 8'h00);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule